// File: doc/BRIEF.md
# Chainable Serial Command Receiver with Frame-Length Check

This block is the serial front end of a register-controlled device. A bus master drives a chip select, a serial clock and a data line. All of these are sampled on a fast system clock. Every serial clock pulse moves one bit from the data input into a 16-bit shift register and moves one bit out on the serial output. Because of this, several devices can share one chip select with the output of each device wired to the input of the next: after 16 clocks, the data meant for one device has passed on to its neighbour.

When chip select falls, the shift register is loaded in parallel from a status input, so that the status word is the first thing the master reads back. When chip select rises, the block counts the serial clock pulses of the frame. A count of 16 plus a whole multiple of 8 is a good frame. For a good frame, the last 16 bits in the shift register are presented as a command word on a valid/ready output. Any other count, or a serial clock that is high while chip select changes, makes a bad frame. A bad frame drops the command and sets a sticky transmission-error flag. That flag is merged into the most significant bit of the next status word that is loaded.

The command output follows valid/ready rules. `wr_valid_o` rises for one accepted frame and stays high, with `wr_data_o` unchanged, until a cycle in which `wr_ready_i` is high. If the consumer holds ready high, this gives a single-cycle write strobe. If a second good frame ends while a word is still waiting, the newer word replaces it. The serial clock must run at no more than a quarter of the system clock rate.

Top module: `spi_chain_slave`

## Requirements
- R1: When chip select rises after exactly 16 + 8·n serial clock pulses (n = 0, 1, 2, …) and the serial clock was low at both chip-select edges, `wr_valid_o` rises and `ter_o` does not change.
- R2: When chip select rises after any other pulse count (0, 15, 17, …), no command word is issued and `ter_o` becomes 1.
- R3: If the serial clock is high when chip select falls or rises, the frame is rejected with the same effects as in R2, whatever the pulse count.
- R4: Data input bits are taken on falling serial clock edges and enter at bit 0, so the earliest bit sent ends up most significant. The issued word is the last 16 bits received, with the last bit received in bit 0.
- R5: The serial output changes only on rising serial clock edges and on the chip-select fall. During the first 16 pulses it presents the status word, bit 15 first. After that it repeats the data input delayed by 16 pulses.
- R6: `so_oe_o` is 1 only while chip select is low. The output is released while chip select is high.
- R7: `ter_o` stays at 1 until `ter_clr_i` is pulsed. While it is 1, bit 15 of the status word loaded at chip-select fall reads 1.
- R8: While `wr_valid_o` is 1 and `wr_ready_i` is 0, `wr_valid_o` stays 1 and `wr_data_o` stays unchanged. The word is released in the first cycle in which `wr_ready_i` is 1.
- R9: After reset, `wr_valid_o`, `ter_o` and `so_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn_i | input | 1 | Chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, idle low, asynchronous |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the serial output pad |
| stat_i | input | 16 | Status word loaded at chip-select fall |
| ter_clr_i | input | 1 | Clears the transmission-error flag |
| ter_o | output | 1 | Sticky transmission-error flag |
| wr_valid_o | output | 1 | Command word available |
| wr_ready_i | input | 1 | Consumer accepts the command word |
| wr_data_o | output | 16 | Command word |

## Verification
The bench uses the default parameters: a 16-bit word, a frame step of 8, an 8-bit saturating pulse counter and two synchroniser stages. With these values it can send frames of 16, 24 and 32 pulses and see both the pass-through and the last-16-bits rule. It can also send counts of 0, 15 and 17 that must be rejected. The serial clock runs with 6 system clocks per phase, which leaves room for the synchroniser and edge-detect latency before each master-side sample. Back-pressure is tested by holding ready low across a whole frame end.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  typedef enum logic [1:0] {
    VERDICT_NONE   = 2'd0,
    VERDICT_ACCEPT = 2'd1,
    VERDICT_REJECT = 2'd2
  } verdict_e;

  function automatic int unsigned log2_ceil(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction
endpackage

// File: rtl/spi_chain_sync.sv
module spi_chain_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RST_VAL}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_chain_shifter.sv
module spi_chain_shifter #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift_en,
  input  logic              shift_in,
  input  logic              out_en,
  output logic [WORD_W-1:0] word,
  output logic              so_bit,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      bit_cnt <= '0;
    end else if (load) begin
      word    <= load_word;
      bit_cnt <= '0;
    end else if (shift_en) begin
      word <= {word[WORD_W-2:0], shift_in};
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      so_bit <= 1'b0;
    else if (load)   so_bit <= load_word[WORD_W-1];
    else if (out_en) so_bit <= word[WORD_W-1];
  end
endmodule

// File: rtl/spi_chain_judge.sv
module spi_chain_judge
  import spi_chain_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int STEP   = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_fall,
  input  logic              csn_rise,
  input  logic              sclk_lvl,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [WORD_W-1:0] word,
  input  logic              ter_clr,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_data,
  output logic              ter,
  output verdict_e          verdict
);
  localparam int          STEP_LG = log2_ceil(STEP);
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(WORD_W);
  localparam logic [STEP_LG-1:0] MIN_LOW = MIN_CNT[STEP_LG-1:0];

  logic sclk_bad;
  logic len_ok;

  assign len_ok = (bit_cnt >= MIN_CNT) && (bit_cnt[STEP_LG-1:0] == MIN_LOW);

  always_comb begin
    verdict = VERDICT_NONE;
    if (csn_rise)
      verdict = (len_ok && !sclk_bad && !sclk_lvl) ? VERDICT_ACCEPT : VERDICT_REJECT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sclk_bad <= 1'b0;
    else if (csn_fall) sclk_bad <= sclk_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else if (verdict == VERDICT_ACCEPT) begin
      wr_valid <= 1'b1;
      wr_data  <= word;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         ter <= 1'b0;
    else if (verdict == VERDICT_REJECT) ter <= 1'b1;
    else if (ter_clr)                   ter <= 1'b0;
  end
endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave
  import spi_chain_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int STEP   = 8,
  parameter int CNT_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  input  logic [WORD_W-1:0] stat_i,
  input  logic              ter_clr_i,
  output logic              ter_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [WORD_W-1:0] wr_data_o
);
  logic [2:0] pins_s;
  logic csn_s, sclk_s, si_s;
  logic csn_d, sclk_d;
  logic csn_fall, csn_rise, sclk_rise, sclk_fall;
  logic [WORD_W-1:0] load_word;
  logic [WORD_W-1:0] sh_word;
  logic [CNT_W-1:0]  bit_cnt;
  verdict_e verdict;

  spi_chain_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({csn_i, sclk_i, si_i}), .q(pins_s)
  );
  assign {csn_s, sclk_s, si_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_d  <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      csn_d  <= csn_s;
      sclk_d <= sclk_s;
    end
  end

  assign csn_fall  = csn_d & ~csn_s;
  assign csn_rise  = ~csn_d & csn_s;
  assign sclk_rise = ~sclk_d & sclk_s;
  assign sclk_fall = sclk_d & ~sclk_s;

  assign load_word = {stat_i[WORD_W-1] | ter_o, stat_i[WORD_W-2:0]};

  spi_chain_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(csn_fall), .load_word(load_word),
    .shift_en(sclk_fall & ~csn_s), .shift_in(si_s),
    .out_en(sclk_rise & ~csn_s),
    .word(sh_word), .so_bit(so_o), .bit_cnt(bit_cnt)
  );

  spi_chain_judge #(.WORD_W(WORD_W), .STEP(STEP), .CNT_W(CNT_W)) u_judge (
    .clk(clk), .rst_n(rst_n),
    .csn_fall(csn_fall), .csn_rise(csn_rise), .sclk_lvl(sclk_s),
    .bit_cnt(bit_cnt), .word(sh_word),
    .ter_clr(ter_clr_i), .wr_ready(wr_ready_i),
    .wr_valid(wr_valid_o), .wr_data(wr_data_o),
    .ter(ter_o), .verdict(verdict)
  );

  assign so_oe_o = ~csn_s;
endmodule

// File: rtl/spi_chain_slave_chk.sv
module spi_chain_slave_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [WORD_W-1:0] wr_data,
  input logic              ter,
  input logic              ter_clr,
  input logic              frame_end,
  input logic              so,
  input logic              sclk_rise,
  input logic              csn_fall
);
  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data))); // R8

  AST_WRITE_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(frame_end)); // R1

  AST_TER_FROM_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ter) |-> $past(frame_end)); // R2

  AST_NO_WRITE_WITH_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(ter) && $rose(wr_valid))); // R2

  AST_TER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ter && !ter_clr) |=> ter); // R7

  AST_SO_ON_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_rise && !csn_fall) |=> $stable(so)); // R5
endmodule

bind spi_chain_slave spi_chain_slave_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .wr_valid(wr_valid_o), .wr_ready(wr_ready_i), .wr_data(wr_data_o),
  .ter(ter_o), .ter_clr(ter_clr_i), .frame_end(csn_rise),
  .so(so_o), .sclk_rise(sclk_rise), .csn_fall(csn_fall)
);

// File: tb/spi_chain_slave_tb.sv
`timescale 1ns/1ps
module spi_chain_slave_tb;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, si = 1'b0;
  logic so, so_oe, ter, ter_clr = 1'b0;
  logic wr_valid, wr_ready = 1'b1;
  logic [15:0] stat = 16'h0000, wr_data;

  int checks = 0, fails = 0;
  logic [15:0] exp_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  spi_chain_slave u_dut (
    .clk(clk), .rst_n(rst_n), .csn_i(csn), .sclk_i(sclk), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .stat_i(stat), .ter_clr_i(ter_clr),
    .ter_o(ter), .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_data_o(wr_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: each handshake pops one expected word.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && wr_valid && wr_ready) begin
        if (exp_q.size() == 0) begin
          chk("R2 unexpected write", {16'h0, wr_data}, 32'hDEAD_BEEF);
        end else begin
          chk("R1/R4 write word", {16'h0, wr_data}, {16'h0, exp_q.pop_front()});
        end
      end
    end
  end

  // Driver: n pulses, bits sent earliest first (bits[n-1] first).
  task automatic frame(input int n, input logic [63:0] bits, input logic [15:0] exp_stat,
                       input bit hi_end, input bit ok);
    logic expbit;
    csn = 1'b0;
    wait_clk(H);
    chk("R6 oe while selected", {31'h0, so_oe}, 32'h1);
    for (int k = 0; k < n; k++) begin
      si = bits[n-1-k];
      sclk = 1'b1;
      wait_clk(H);
      expbit = (k < 16) ? exp_stat[15-k] : bits[n-1-(k-16)];
      chk("R5 so bit", {31'h0, so}, {31'h0, expbit});
      sclk = 1'b0;
      wait_clk(H);
    end
    if (hi_end) begin
      sclk = 1'b1;
      wait_clk(H);
    end
    if (ok) exp_q.push_back(bits[15:0]);
    csn = 1'b1;
    wait_clk(2*H);
    sclk = 1'b0;
    wait_clk(H);
    chk("R6 released when deselected", {31'h0, so_oe}, 32'h0);
  endtask

  task automatic clear_ter();
    ter_clr = 1'b1;
    wait_clk(1);
    ter_clr = 1'b0;
    wait_clk(2);
    chk("R7 ter cleared", {31'h0, ter}, 32'h0);
  endtask

  initial begin
    #(8*200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait_clk(5);
    chk("R9 reset valid", {31'h0, wr_valid}, 32'h0);
    chk("R9 reset ter", {31'h0, ter}, 32'h0);
    chk("R9 reset oe", {31'h0, so_oe}, 32'h0);
    rst_n = 1'b1;
    wait_clk(4);

    // R1/R4/R5: 16-pulse frame
    stat = 16'hA5C3;
    frame(16, 64'h1234, 16'hA5C3, 0, 1);
    chk("R1 no error on good frame", {31'h0, ter}, 32'h0);

    // R4/R5: 24 and 32 pulse frames, last 16 bits kept, pass-through
    stat = 16'h0F0F;
    frame(24, 64'hABCDEF, 16'h0F0F, 0, 1);
    frame(32, 64'h8001_7FFE, 16'h0F0F, 0, 1);
    chk("R1 no error after long frames", {31'h0, ter}, 32'h0);

    // R2: 15 pulses
    frame(15, 64'h1FFF, 16'h0F0F, 0, 0);
    chk("R2 ter after 15", {31'h0, ter}, 32'h1);
    // R7: ter visible in status bit 15, and sticky
    frame(16, 64'h5555, 16'h8F0F, 0, 1);
    chk("R7 ter sticky", {31'h0, ter}, 32'h1);
    clear_ter();

    // R2: 17 pulses, then 0 pulses
    frame(17, 64'h1_2345, 16'h0F0F, 0, 0);
    chk("R2 ter after 17", {31'h0, ter}, 32'h1);
    clear_ter();
    frame(0, 64'h0, 16'h0F0F, 0, 0);
    chk("R2 ter after 0", {31'h0, ter}, 32'h1);
    clear_ter();

    // R3: clock high at chip-select rise with a good count
    frame(16, 64'hBEEF, 16'h0F0F, 1, 0);
    chk("R3 ter on high clock at end", {31'h0, ter}, 32'h1);
    clear_ter();

    // R3: clock high at chip-select fall
    sclk = 1'b1;
    wait_clk(H);
    csn = 1'b0;
    wait_clk(H);
    sclk = 1'b0;
    wait_clk(H);
    for (int k = 0; k < 16; k++) begin
      sclk = 1'b1; wait_clk(H);
      sclk = 1'b0; wait_clk(H);
    end
    csn = 1'b1;
    wait_clk(3*H);
    chk("R3 ter on high clock at start", {31'h0, ter}, 32'h1);
    clear_ter();

    // R8: back-pressure
    wr_ready = 1'b0;
    frame(16, 64'hC0DE, 16'h0F0F, 0, 1);
    for (int i = 0; i < 10; i++) begin
      chk("R8 valid held", {31'h0, wr_valid}, 32'h1);
      chk("R8 data held", {16'h0, wr_data}, 32'h0000_C0DE);
      wait_clk(1);
    end
    wr_ready = 1'b1;
    wait_clk(3);
    chk("R8 released after ready", {31'h0, wr_valid}, 32'h0);

    wait_clk(5);
    chk("R1 all expected words seen", exp_q.size(), 32'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule